// File: doc/BRIEF.md
# Suspend-Resume Refresh Mode Controller

This block sits in the PCI clock domain of a memory controller. It decides when the controller leaves suspend refresh. Two asynchronous inputs drive that decision: a suspend clock and an active-low suspend status. The first PCI-clock sample on which suspend status reads inactive (high) is the decision point. The level of the suspend clock on that sample picks the outcome. A high level means the clock is running, and the block moves to normal refresh with its configuration intact. A low level means the clock is stopped, and the block performs a one-clock resume-well reset that restores every configuration register to its default before normal refresh starts. The suspend clock is used with its natural polarity and is never inverted.

The block also holds two resume-well configuration registers: a refresh idle count (default 14h) and a refresh interval. In normal refresh, a down-counter reloads from the interval, emits a one-cycle refresh request each time it expires, and then holds a busy output for the number of clocks given by the idle count. A plain write port updates the registers. When suspend status returns to active, the block goes back to suspend refresh and stays quiet.

Top module: `susp_refresh_ctrl`

## Requirements
- R1: After reset the block is in suspend refresh: `inSuspend`=1, `refreshReq`=0, `refreshBusy`=0, `wellReset`=0, `cfgIdleCount`=14h, `cfgInterval`=DEF_INTERVAL (20h by default).
- R2: Both inputs pass through a two-flop synchronizer. If suspend status is first seen inactive while the suspend clock is high, `inSuspend` falls after the third rising edge following the input change. `wellReset` stays low and the configuration is kept.
- R3: If suspend status is first seen inactive while the suspend clock is low, `wellReset` is high for exactly one cycle, starting after the third edge. At the edge that ends it, both configuration registers return to their defaults and `inSuspend` falls.
- R4: Further samples while suspend status stays inactive are ignored. Toggling the suspend clock then causes no `wellReset` and no change of mode or configuration.
- R5: When suspend status goes active (low), `inSuspend` rises after the third rising edge following the change.
- R6: From the second cycle of suspend refresh onward, `refreshReq` and `refreshBusy` are low.
- R7: In normal refresh, `refreshReq` is a one-cycle pulse. The first pulse comes interval+1 cycles after `inSuspend` falls, and each following pulse comes every interval+1 cycles.
- R8: `refreshBusy` is high for exactly idle-count cycles, starting in the cycle of each `refreshReq` pulse. An idle count of 0 gives no busy cycles.
- R9: A write with `wrEn`=1 updates a register from the next cycle: address 0 holds the idle count and address 1 holds the refresh interval. Writes to any other address change nothing.
- R10: A write presented in the same cycle that `wellReset` is high is discarded, and the defaults win.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rstN | input | 1 | Active-low asynchronous reset |
| suspClkIn | input | 1 | Suspend clock (high = running), asynchronous |
| suspStatN | input | 1 | Suspend status, active low, asynchronous |
| wrEn | input | 1 | Configuration write enable |
| wrAddr | input | ADDR_W | Configuration write address |
| wrData | input | DATA_W | Configuration write data |
| refreshReq | output | 1 | One-cycle normal refresh request |
| refreshBusy | output | 1 | Idle window after a refresh request |
| inSuspend | output | 1 | High while in suspend refresh |
| wellReset | output | 1 | One-cycle resume-well reset pulse |
| cfgIdleCount | output | DATA_W | Current refresh idle count |
| cfgInterval | output | DATA_W | Current refresh interval |

## Verification
A configuration write and the resume-well default load can land on the same clock edge, and only one of them may win. The bench waits until it observes `wellReset` high, then drives a write to the idle-count register so that the write meets the reset edge. It judges the outcome from `cfgIdleCount`, which must read 14h afterwards. A write made on the following cycle must then take effect, which shows the port is not left blocked.

// File: rtl/susp_refresh_pkg.sv
`timescale 1ns/1ps
package susp_refresh_pkg;
  localparam int IDX_IDLE     = 0;
  localparam int IDX_INTERVAL = 1;
  localparam int NUM_CFG      = 2;

  typedef enum logic {MODE_SUSPEND = 1'b0, MODE_NORMAL = 1'b1} refresh_mode_t;

  typedef struct packed {
    logic runNormal;
    logic loadDefaults;
  } ctrl_strobes_t;
endpackage

// File: rtl/susp_refresh_sync.sv
`timescale 1ns/1ps
module susp_refresh_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= asyncIn;
      stage2 <= stage1;
    end
  end

  assign syncOut = stage2;
endmodule

// File: rtl/susp_refresh_fsm.sv
`timescale 1ns/1ps
module susp_refresh_fsm
  import susp_refresh_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          clkSync,
  input  logic          statSync,
  output ctrl_strobes_t strobes,
  output logic          inSuspend,
  output logic          wellReset
);
  refresh_mode_t mode;
  logic statPrev;
  logic wellRstQ;
  logic firstInactive;

  // rising edge of the synchronized status marks the deciding sample
  assign firstInactive = statSync & ~statPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= MODE_SUSPEND;
      statPrev <= 1'b0;
      wellRstQ <= 1'b0;
    end else begin
      statPrev <= statSync;
      wellRstQ <= firstInactive & ~clkSync;
      if (wellRstQ)
        mode <= MODE_NORMAL;
      else if (!statSync)
        mode <= MODE_SUSPEND;
      else if (firstInactive && clkSync)
        mode <= MODE_NORMAL;
    end
  end

  assign strobes.runNormal    = (mode == MODE_NORMAL);
  assign strobes.loadDefaults = wellRstQ;
  assign inSuspend            = (mode == MODE_SUSPEND);
  assign wellReset            = wellRstQ;
endmodule

// File: rtl/susp_refresh_dp.sv
`timescale 1ns/1ps
module susp_refresh_dp
  import susp_refresh_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int ADDR_W       = 2,
  parameter int DEF_IDLE     = 'h14,
  parameter int DEF_INTERVAL = 'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobes_t     strobes,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              refreshReq,
  output logic              refreshBusy,
  output logic [DATA_W-1:0] cfgIdleCount,
  output logic [DATA_W-1:0] cfgInterval
);
  localparam logic [DATA_W-1:0] DefIdle = DATA_W'(DEF_IDLE);
  localparam logic [DATA_W-1:0] DefIntv = DATA_W'(DEF_INTERVAL);

  function automatic logic [DATA_W-1:0] defaultOf(input int idx);
    return (idx == IDX_IDLE) ? DefIdle : DefIntv;
  endfunction

  logic [DATA_W-1:0] cfgQ [NUM_CFG];
  logic [DATA_W-1:0] downCnt;
  logic [DATA_W-1:0] busyCnt;
  logic              reqQ;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cfgQ[g] <= defaultOf(g);
      else if (strobes.loadDefaults)
        cfgQ[g] <= defaultOf(g);
      else if (wrEn && wrAddr == ADDR_W'(g))
        cfgQ[g] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      downCnt <= DefIntv;
      busyCnt <= '0;
      reqQ    <= 1'b0;
    end else if (!strobes.runNormal) begin
      downCnt <= strobes.loadDefaults ? DefIntv : cfgQ[IDX_INTERVAL];
      busyCnt <= '0;
      reqQ    <= 1'b0;
    end else if (downCnt == '0) begin
      downCnt <= cfgQ[IDX_INTERVAL];
      busyCnt <= cfgQ[IDX_IDLE];
      reqQ    <= 1'b1;
    end else begin
      downCnt <= downCnt - 1'b1;
      reqQ    <= 1'b0;
      if (busyCnt != '0)
        busyCnt <= busyCnt - 1'b1;
    end
  end

  assign refreshReq   = reqQ;
  assign refreshBusy  = (busyCnt != '0);
  assign cfgIdleCount = cfgQ[IDX_IDLE];
  assign cfgInterval  = cfgQ[IDX_INTERVAL];
endmodule

// File: rtl/susp_refresh_ctrl.sv
`timescale 1ns/1ps
module susp_refresh_ctrl
  import susp_refresh_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int ADDR_W       = 2,
  parameter int DEF_IDLE     = 'h14,
  parameter int DEF_INTERVAL = 'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              suspClkIn,
  input  logic              suspStatN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              refreshReq,
  output logic              refreshBusy,
  output logic              inSuspend,
  output logic              wellReset,
  output logic [DATA_W-1:0] cfgIdleCount,
  output logic [DATA_W-1:0] cfgInterval
);
  logic [1:0]    syncVec;
  ctrl_strobes_t strobes;

  susp_refresh_sync #(.WIDTH(2)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({suspClkIn, suspStatN}),
    .syncOut(syncVec)
  );

  susp_refresh_fsm u_fsm (
    .clk(clk), .rstN(rstN),
    .clkSync(syncVec[1]), .statSync(syncVec[0]),
    .strobes(strobes), .inSuspend(inSuspend), .wellReset(wellReset)
  );

  susp_refresh_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .DEF_IDLE(DEF_IDLE), .DEF_INTERVAL(DEF_INTERVAL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .refreshReq(refreshReq), .refreshBusy(refreshBusy),
    .cfgIdleCount(cfgIdleCount), .cfgInterval(cfgInterval)
  );
endmodule

// File: rtl/susp_refresh_checks.sv
`timescale 1ns/1ps
module susp_refresh_checks #(
  parameter int DATA_W       = 8,
  parameter int DEF_IDLE     = 'h14,
  parameter int DEF_INTERVAL = 'h20
) (
  input logic              clk,
  input logic              rstN,
  input logic              refreshReq,
  input logic              refreshBusy,
  input logic              inSuspend,
  input logic              wellReset,
  input logic [DATA_W-1:0] cfgIdleCount,
  input logic [DATA_W-1:0] cfgInterval
);
  assert_well_reset_one_cycle_R3: assert property (@(posedge clk) disable iff (!rstN)
    wellReset |=> !wellReset);

  assert_well_reset_leaves_suspend_R3: assert property (@(posedge clk) disable iff (!rstN)
    wellReset |=> !inSuspend);

  assert_well_reset_defaults_R10: assert property (@(posedge clk) disable iff (!rstN)
    wellReset |=> (cfgIdleCount == DATA_W'(DEF_IDLE)) && (cfgInterval == DATA_W'(DEF_INTERVAL)));

  assert_well_reset_only_in_suspend_R4: assert property (@(posedge clk) disable iff (!rstN)
    wellReset |-> inSuspend);

  assert_quiet_in_suspend_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inSuspend && $past(inSuspend)) |-> (!refreshReq && !refreshBusy));

  assert_req_single_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (refreshReq && cfgInterval != '0) |=> !refreshReq);
endmodule

bind susp_refresh_ctrl susp_refresh_checks #(
  .DATA_W(DATA_W), .DEF_IDLE(DEF_IDLE), .DEF_INTERVAL(DEF_INTERVAL)
) u_checks (
  .clk(clk), .rstN(rstN), .refreshReq(refreshReq), .refreshBusy(refreshBusy),
  .inSuspend(inSuspend), .wellReset(wellReset),
  .cfgIdleCount(cfgIdleCount), .cfgInterval(cfgInterval)
);

// File: tb/tb_susp_refresh_ctrl.sv
`timescale 1ns/1ps
module tb_susp_refresh_ctrl;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int DEF_IDLE = 'h14;
  localparam int DEF_INTERVAL = 'h20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic suspClkIn = 1'b0;
  logic suspStatN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic refreshReq, refreshBusy, inSuspend, wellReset;
  logic [DATA_W-1:0] cfgIdleCount, cfgInterval;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int expIdle = DEF_IDLE;
  int expIntv = DEF_INTERVAL;

  always #2 clk = ~clk;

  susp_refresh_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .DEF_IDLE(DEF_IDLE), .DEF_INTERVAL(DEF_INTERVAL)) dut (
    .clk(clk), .rstN(rstN), .suspClkIn(suspClkIn), .suspStatN(suspStatN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .refreshReq(refreshReq), .refreshBusy(refreshBusy), .inSuspend(inSuspend),
    .wellReset(wellReset), .cfgIdleCount(cfgIdleCount), .cfgInterval(cfgInterval));

  function automatic bit reqAt(int i, int n);
    return (i % (n + 1)) == 0;
  endfunction

  function automatic bit busyAt(int i, int n, int idle);
    return (i >= n + 1) && (((i - (n + 1)) % (n + 1)) < idle);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeReg(int addr, int data);
    wrEn = 1'b1; wrAddr = ADDR_W'(addr); wrData = DATA_W'(data);
    step();
    wrEn = 1'b0;
  endtask

  task automatic checkCfg(string req);
    check({req, " idle"}, int'(cfgIdleCount), expIdle);
    check({req, " interval"}, int'(cfgInterval), expIntv);
  endtask

  // exit with a given suspend clock level; returns with the exit observed
  task automatic doExit(bit clkHigh);
    suspClkIn = clkHigh;
    repeat (3) step();
    suspStatN = 1'b1;
    step(); step();
    check("R2 still suspended before decision", int'(inSuspend), 1);
    step();
    if (clkHigh) begin
      check("R2 normal exit inSuspend", int'(inSuspend), 0);
      check("R2 no wellReset", int'(wellReset), 0);
      checkCfg("R2 config kept");
    end else begin
      check("R3 wellReset high", int'(wellReset), 1);
      check("R3 still suspended during reset", int'(inSuspend), 1);
      step();
      expIdle = DEF_IDLE; expIntv = DEF_INTERVAL;
      check("R3 wellReset one cycle", int'(wellReset), 0);
      check("R3 exit after reset", int'(inSuspend), 0);
      checkCfg("R3 defaults");
    end
  endtask

  task automatic checkRefresh();
    int errBefore = errors;
    for (int i = 1; i <= 2 * (expIntv + 1); i++) begin
      step();
      if (int'(refreshReq) != int'(reqAt(i, expIntv)))
        check("R7 refresh request timing", int'(refreshReq), int'(reqAt(i, expIntv)));
      if (int'(refreshBusy) != int'(busyAt(i, expIntv, expIdle)))
        check("R8 busy window", int'(refreshBusy), int'(busyAt(i, expIntv, expIdle)));
    end
    if (errors == errBefore) checks += 2;
  endtask

  task automatic ignoreLater();
    suspClkIn = ~suspClkIn;
    repeat (4) begin
      step();
      check("R4 later sample no wellReset", int'(wellReset), 0);
    end
    suspClkIn = ~suspClkIn;
    repeat (4) step();
    check("R4 stays normal", int'(inSuspend), 0);
    checkCfg("R4 config untouched");
  endtask

  task automatic enterSuspend();
    suspStatN = 1'b0;
    step(); step(); step();
    check("R5 suspend entry", int'(inSuspend), 1);
    step();
    repeat (6) begin
      step();
      check("R6 no request in suspend", int'(refreshReq), 0);
      check("R6 no busy in suspend", int'(refreshBusy), 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) step();
    rstN = 1'b1;
    step();
    check("R1 reset inSuspend", int'(inSuspend), 1);
    check("R1 reset refreshReq", int'(refreshReq), 0);
    check("R1 reset busy", int'(refreshBusy), 0);
    check("R1 reset wellReset", int'(wellReset), 0);
    checkCfg("R1 reset defaults");

    // R9 writes, including an unmapped address
    writeReg(0, 3); expIdle = 3;
    writeReg(1, 6); expIntv = 6;
    checkCfg("R9 write");
    writeReg(2, 'hAA);
    writeReg(3, 'h55);
    checkCfg("R9 unmapped address ignored");

    doExit(1'b1);
    checkRefresh();
    ignoreLater();
    enterSuspend();

    // R10 collision of a write with the resume-well reset
    writeReg(0, 9); expIdle = 9;
    suspClkIn = 1'b0;
    repeat (3) step();
    suspStatN = 1'b1;
    repeat (3) step();
    check("R3 wellReset seen for collision", int'(wellReset), 1);
    wrEn = 1'b1; wrAddr = '0; wrData = 8'h55;
    step();
    wrEn = 1'b0;
    expIdle = DEF_IDLE; expIntv = DEF_INTERVAL;
    checkCfg("R10 write discarded during reset");
    writeReg(0, 7); expIdle = 7;
    checkCfg("R10 write after reset lands");
    expIdle = 7;
    enterSuspend();

    // constrained random rounds
    for (int r = 0; r < 6; r++) begin
      int n = 2 + int'($urandom_range(0, 8));
      int idl = int'($urandom_range(0, n));
      bit lvl = 1'($urandom_range(0, 1));
      writeReg(1, n); expIntv = n;
      writeReg(0, idl); expIdle = idl;
      doExit(lvl);
      checkRefresh();
      ignoreLater();
      enterSuspend();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule